// File: doc/BRIEF.md
# Serial Port Register and Interrupt Controller

This block is the software-facing side of an asynchronous serial port. A processor reaches it through a simple 32-bit register bus with a write strobe and a read strobe. It keeps the frame format, the baud divider and the pin routing as stored configuration, and it passes them out to the serial shifter, which lives outside the block. Bytes travel between this block and that shifter over valid/ready handshakes. Two small buffers sit between the bus and the shifter: a receive buffer holding data with its error bits, and a transmit buffer.

Enable and disable commands are one-shot bits. Two small state machines turn them into the receiver and transmitter states. The receiver machine has two states, `RX_OFF` and `RX_ON`. An enable command moves it from `RX_OFF` to `RX_ON`, and a disable command moves it back. The transmitter machine has three states: `TX_OFF`, `TX_IDLE` and `TX_BUSY`. An enable command moves it from `TX_OFF` to `TX_IDLE`. From `TX_IDLE` it moves to `TX_BUSY` when the buffer holds data. It moves from `TX_BUSY` back to `TX_IDLE` once the buffer is empty and the shifter is idle, and that transition raises the transmit-complete event. A disable command sends it from either `TX_IDLE` or `TX_BUSY` to `TX_OFF`.

Interrupt flags can be set or cleared by writing masks to two alias addresses. A single interrupt line is the OR of the flags gated by an enable mask.

Top module: `serial_ctl_regs`

## Requirements
- R1: Writable registers read back their stored fields: control bit 12 at 0x00; frame at 0x04 with mask 0x330F, which also drives `frame_cfg`; divider bits 20:6 at 0x14, which also drive `clk_div`; interrupt enable at 0x4C with mask 0x17. Reads of the command address and of unmapped addresses return zero.
- R2: A write to 0x0C acts for that cycle only. Bit0 enables the receiver, bit1 disables it, bit2 enables the transmitter and bit3 disables it. When enable and disable are both set, disable wins. `rx_ready` is high only while the receiver is enabled.
- R3: Status at 0x10 shows bit1 when the transmitter is enabled, bit5 when the transmitter is in `TX_IDLE`, bit6 for the transmit buffer level, and bit7 when the receive buffer is not empty. After reset it reads 0x40.
- R4: When control bit 12 is set, the buffer-level condition holds only when the transmit buffer is empty. When it is clear, the condition holds whenever fewer than two entries are stored.
- R5: A read of 0x18 returns the oldest received entry and removes it: data in bits 8:0, parity error in bit 14, framing error in bit 15. A read of an empty buffer returns zero and changes nothing. The buffer holds two entries.
- R6: A byte offered while the receive buffer is full is dropped, and flag bit4 is set.
- R7: Flags read at 0x40. Bits 0 (transmit complete), 2 (receive data) and 4 (overflow) are sticky: writes to 0x44 set them and writes to 0x48 clear them, and a clear beats a hardware set in the same cycle. Bit1 follows the buffer-level condition and ignores both writes. After reset the flags read 0x02.
- R8: `irq` equals the OR over all bits of the flags ANDed with the enable mask.
- R9: Writes to 0x34 while the transmitter is enabled are queued, up to two entries, and offered on `tx_valid`/`tx_data` in order. Writes made while the transmitter is disabled or the buffer is full are dropped.
- R10: The move from `TX_BUSY` to `TX_IDLE` sets flag bit0. That move happens only after the buffer is empty and `tx_busy` is low.
- R11: Disabling the transmitter empties its buffer. Disabling the receiver keeps the stored entries readable and refuses new bytes.
- R12: Route at 0x54 keeps bit0 (`rx_pin_en`), bit1 (`tx_pin_en`) and bits 10:8 (`pin_loc`). It reads back with mask 0x703.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of `rd_en` |
| rx_valid | input | 1 | Shifter offers a received byte |
| rx_data | input | 9 | Received data |
| rx_perr | input | 1 | Parity error of the offered byte |
| rx_ferr | input | 1 | Framing error of the offered byte |
| rx_ready | output | 1 | Receiver enabled; byte taken when valid |
| tx_valid | output | 1 | A byte is waiting for the shifter |
| tx_data | output | 9 | Byte to send |
| tx_ready | input | 1 | Shifter takes the byte |
| tx_busy | input | 1 | Shifter is sending; high from the cycle after a take |
| frame_cfg | output | 16 | Stored frame format |
| clk_div | output | 15 | Stored baud divider |
| rx_pin_en | output | 1 | Receive pin enable |
| tx_pin_en | output | 1 | Transmit pin enable |
| pin_loc | output | 3 | Pin location selector |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: 9-bit data and two entries in each buffer. With such shallow buffers, a third byte on either side reaches the full-buffer cases at once. On the receive side that is overflow and its flag; on the transmit side it is a dropped write and the two threshold settings of the level flag at one entry. A long random run mixes received bytes, buffer reads, set and clear masks and enable masks, and checks the interrupt line against a model. A directed case lines up a clear write with an overflow in the same cycle.

// File: rtl/serial_ctl_pkg.sv
package serial_ctl_pkg;

    // register byte offsets
    localparam int OFS_CTRL   = 'h00;
    localparam int OFS_FRAME  = 'h04;
    localparam int OFS_CMD    = 'h0C;
    localparam int OFS_STATUS = 'h10;
    localparam int OFS_DIV    = 'h14;
    localparam int OFS_RXD    = 'h18;
    localparam int OFS_TXD    = 'h34;
    localparam int OFS_FLAGS  = 'h40;
    localparam int OFS_FSET   = 'h44;
    localparam int OFS_FCLR   = 'h48;
    localparam int OFS_IEN    = 'h4C;
    localparam int OFS_ROUTE  = 'h54;

    // flag bit positions
    localparam int FLG_TXC  = 0;
    localparam int FLG_TXBL = 1;
    localparam int FLG_RXV  = 2;
    localparam int FLG_RXOF = 4;
    localparam int FLAG_W   = 8;

    localparam logic [FLAG_W-1:0] STICKY_MASK = 8'h15;
    localparam logic [FLAG_W-1:0] LEVEL_MASK  = 8'h02;
    localparam logic [FLAG_W-1:0] IEN_MASK    = 8'h17;
    localparam logic [15:0]       FRAME_MASK  = 16'h330F;

    typedef enum logic [1:0] {
        TX_OFF,
        TX_IDLE,
        TX_BUSY
    } tx_state_e;

    typedef enum logic {
        RX_OFF,
        RX_ON
    } rx_state_e;

endpackage

// File: rtl/sc_buf.sv
module sc_buf #(
    parameter int W     = 9,
    parameter int DEPTH = 2,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          flush,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        if (p == PW'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= din;
    end

endmodule

// File: rtl/sc_flags.sv
module sc_flags #(
    parameter int              W      = 8,
    parameter logic [W-1:0]    STICKY = 8'h15,
    parameter logic [W-1:0]    LEVEL  = 8'h02
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hw_set,
    input  logic [W-1:0] sw_set,
    input  logic [W-1:0] sw_clr,
    input  logic [W-1:0] level,
    input  logic [W-1:0] ien,
    output logic [W-1:0] flags,
    output logic         irq
);

    logic [W-1:0] sticky_q;

    // a clear mask overrides both hardware and software set requests
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sticky_q <= '0;
        else        sticky_q <= ((sticky_q | hw_set | sw_set) & ~sw_clr) & STICKY;
    end

    assign flags = sticky_q | (level & LEVEL);
    assign irq   = |(flags & ien);

endmodule

// File: rtl/serial_ctl_regs.sv
module serial_ctl_regs
    import serial_ctl_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 9,
    parameter int RX_DEPTH = 2,
    parameter int TX_DEPTH = 2,
    parameter int LOC_W    = 3,
    parameter int DIV_W    = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              tx_busy,
    output logic [15:0]       frame_cfg,
    output logic [DIV_W-1:0]  clk_div,
    output logic              rx_pin_en,
    output logic              tx_pin_en,
    output logic [LOC_W-1:0]  pin_loc,
    output logic              irq
);

    localparam int RX_W  = DATA_W + 2;
    localparam int RXC_W = $clog2(RX_DEPTH + 1);
    localparam int TXC_W = $clog2(TX_DEPTH + 1);

    // ---------------- address decode ----------------
    logic wr_ctrl, wr_frame, wr_cmd, wr_div, wr_txd, wr_fset, wr_fclr, wr_ien, wr_route;
    logic rd_rxd;

    always_comb begin
        wr_ctrl  = wr_en && (addr == ADDR_W'(OFS_CTRL));
        wr_frame = wr_en && (addr == ADDR_W'(OFS_FRAME));
        wr_cmd   = wr_en && (addr == ADDR_W'(OFS_CMD));
        wr_div   = wr_en && (addr == ADDR_W'(OFS_DIV));
        wr_txd   = wr_en && (addr == ADDR_W'(OFS_TXD));
        wr_fset  = wr_en && (addr == ADDR_W'(OFS_FSET));
        wr_fclr  = wr_en && (addr == ADDR_W'(OFS_FCLR));
        wr_ien   = wr_en && (addr == ADDR_W'(OFS_IEN));
        wr_route = wr_en && (addr == ADDR_W'(OFS_ROUTE));
        rd_rxd   = rd_en && (addr == ADDR_W'(OFS_RXD));
    end

    // one-shot command bits
    logic rx_on_req, rx_off_req, tx_on_req, tx_off_req;
    assign rx_on_req  = wr_cmd && wdata[0];
    assign rx_off_req = wr_cmd && wdata[1];
    assign tx_on_req  = wr_cmd && wdata[2];
    assign tx_off_req = wr_cmd && wdata[3];

    // ---------------- configuration registers ----------------
    logic              lvl_empty_q;
    logic [15:0]       frame_q;
    logic [DIV_W-1:0]  div_q;
    logic [FLAG_W-1:0] ien_q;
    logic              rxpen_q, txpen_q;
    logic [LOC_W-1:0]  loc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_empty_q <= 1'b0;
            frame_q     <= '0;
            div_q       <= '0;
            ien_q       <= '0;
            rxpen_q     <= 1'b0;
            txpen_q     <= 1'b0;
            loc_q       <= '0;
        end else begin
            if (wr_ctrl)  lvl_empty_q <= wdata[12];
            if (wr_frame) frame_q     <= wdata[15:0] & FRAME_MASK;
            if (wr_div)   div_q       <= wdata[6 +: DIV_W];
            if (wr_ien)   ien_q       <= wdata[FLAG_W-1:0] & IEN_MASK;
            if (wr_route) begin
                rxpen_q <= wdata[0];
                txpen_q <= wdata[1];
                loc_q   <= wdata[8 +: LOC_W];
            end
        end
    end

    assign frame_cfg = frame_q;
    assign clk_div   = div_q;
    assign rx_pin_en = rxpen_q;
    assign tx_pin_en = txpen_q;
    assign pin_loc   = loc_q;

    // ---------------- buffers ----------------
    logic [RX_W-1:0]   rx_head;
    logic [RXC_W-1:0]  rx_cnt;
    logic              rx_empty, rx_full, rx_take, rx_pop, rx_acc, rx_ovf;
    logic [TXC_W-1:0]  tx_cnt;
    logic              tx_empty, tx_full, tx_push, tx_pop;
    logic              tx_on, tx_idle;

    assign rx_take = rx_valid && rx_ready;
    assign rx_pop  = rd_rxd && !rx_empty;
    assign rx_acc  = rx_take && (!rx_full || rx_pop);
    assign rx_ovf  = rx_take && rx_full && !rx_pop;

    sc_buf #(.W(RX_W), .DEPTH(RX_DEPTH)) u_rxbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_take),
        .pop   (rx_pop),
        .flush (1'b0),
        .din   ({rx_ferr, rx_perr, rx_data}),
        .dout  (rx_head),
        .count (rx_cnt),
        .empty (rx_empty),
        .full  (rx_full)
    );

    assign tx_push  = wr_txd && tx_on;
    assign tx_valid = tx_on && !tx_empty;
    assign tx_pop   = tx_valid && tx_ready;

    sc_buf #(.W(DATA_W), .DEPTH(TX_DEPTH)) u_txbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_push),
        .pop   (tx_pop),
        .flush (tx_off_req),
        .din   (wdata[DATA_W-1:0]),
        .dout  (tx_data),
        .count (tx_cnt),
        .empty (tx_empty),
        .full  (tx_full)
    );

    // ---------------- receiver state machine ----------------
    rx_state_e rx_st, rx_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_st <= RX_OFF;
        else        rx_st <= rx_nx;
    end

    always_comb begin
        rx_nx = rx_st;
        unique case (rx_st)
            RX_OFF: if (rx_on_req && !rx_off_req) rx_nx = RX_ON;
            RX_ON:  if (rx_off_req)               rx_nx = RX_OFF;
            default: rx_nx = RX_OFF;
        endcase
    end

    // ---------------- transmitter state machine ----------------
    tx_state_e tx_st, tx_nx;
    logic      handed_q;   // shifter took a byte last cycle; tx_busy not yet visible
    logic      txc_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_st    <= TX_OFF;
            handed_q <= 1'b0;
        end else begin
            tx_st    <= tx_nx;
            handed_q <= tx_pop;
        end
    end

    always_comb begin
        tx_nx   = tx_st;
        txc_evt = 1'b0;
        unique case (tx_st)
            TX_OFF: begin
                if (tx_on_req && !tx_off_req) tx_nx = TX_IDLE;
            end
            TX_IDLE: begin
                if (tx_off_req)     tx_nx = TX_OFF;
                else if (!tx_empty) tx_nx = TX_BUSY;
            end
            TX_BUSY: begin
                if (tx_off_req) begin
                    tx_nx = TX_OFF;
                end else if (tx_empty && !tx_busy && !handed_q) begin
                    tx_nx   = TX_IDLE;
                    txc_evt = 1'b1;
                end
            end
            default: tx_nx = TX_OFF;
        endcase
    end

    // state outputs
    always_comb begin
        rx_ready = (rx_st == RX_ON);
        tx_on    = (tx_st != TX_OFF);
        tx_idle  = (tx_st == TX_IDLE);
    end

    // ---------------- flags and interrupt ----------------
    logic              txbl;
    logic [FLAG_W-1:0] hw_set, sw_set, sw_clr, lvl_vec, flag_vec;

    assign txbl = lvl_empty_q ? tx_empty : (tx_cnt < TXC_W'(TX_DEPTH));

    always_comb begin
        hw_set           = '0;
        hw_set[FLG_TXC]  = txc_evt;
        hw_set[FLG_RXV]  = rx_acc;
        hw_set[FLG_RXOF] = rx_ovf;
        lvl_vec          = '0;
        lvl_vec[FLG_TXBL] = txbl;
        sw_set           = wr_fset ? wdata[FLAG_W-1:0] : '0;
        sw_clr           = wr_fclr ? wdata[FLAG_W-1:0] : '0;
    end

    sc_flags #(.W(FLAG_W), .STICKY(STICKY_MASK), .LEVEL(LEVEL_MASK)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .hw_set (hw_set),
        .sw_set (sw_set),
        .sw_clr (sw_clr),
        .level  (lvl_vec),
        .ien    (ien_q),
        .flags  (flag_vec),
        .irq    (irq)
    );

    // ---------------- read mux ----------------
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == ADDR_W'(OFS_CTRL)) begin
                rdata[12] = lvl_empty_q;
            end else if (addr == ADDR_W'(OFS_FRAME)) begin
                rdata[15:0] = frame_q;
            end else if (addr == ADDR_W'(OFS_STATUS)) begin
                rdata[1] = tx_on;
                rdata[5] = tx_idle;
                rdata[6] = txbl;
                rdata[7] = !rx_empty;
            end else if (addr == ADDR_W'(OFS_DIV)) begin
                rdata[6 +: DIV_W] = div_q;
            end else if (addr == ADDR_W'(OFS_RXD)) begin
                if (!rx_empty) begin
                    rdata[DATA_W-1:0] = rx_head[DATA_W-1:0];
                    rdata[14]         = rx_head[DATA_W];
                    rdata[15]         = rx_head[DATA_W+1];
                end
            end else if (addr == ADDR_W'(OFS_FLAGS)) begin
                rdata[FLAG_W-1:0] = flag_vec;
            end else if (addr == ADDR_W'(OFS_IEN)) begin
                rdata[FLAG_W-1:0] = ien_q;
            end else if (addr == ADDR_W'(OFS_ROUTE)) begin
                rdata[0]          = rxpen_q;
                rdata[1]          = txpen_q;
                rdata[8 +: LOC_W] = loc_q;
            end
        end
    end

endmodule

// File: rtl/sc_checker.sv
module sc_checker
    import serial_ctl_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int RX_DEPTH = 2,
    parameter int RXC_W    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic              irq,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic [FLAG_W-1:0] flags,
    input logic [RXC_W-1:0]  rx_cnt
);

    AST_CLR_BEATS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_FCLR) && wdata[FLG_RXOF]) |=> !flags[FLG_RXOF]); // R7

    AST_IRQ_MASKED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_IEN) && wdata == 32'h0) |=> !irq); // R8

    AST_RX_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_CMD) && wdata[1]) |=> !rx_ready); // R2

    AST_TX_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_CMD) && wdata[3]) |=> !tx_valid); // R11

    AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= RXC_W'(RX_DEPTH)); // R5

endmodule

bind serial_ctl_regs sc_checker #(
    .ADDR_W   (ADDR_W),
    .RX_DEPTH (RX_DEPTH),
    .RXC_W    (RXC_W)
) i_sc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .irq      (irq),
    .rx_ready (rx_ready),
    .tx_valid (tx_valid),
    .flags    (flag_vec),
    .rx_cnt   (rx_cnt)
);

// File: tb/test_serial_ctl_regs.sv
module test_serial_ctl_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rx_valid = 1'b0;
    logic [8:0]  rx_data = '0;
    logic        rx_perr = 1'b0, rx_ferr = 1'b0;
    logic        rx_ready, tx_valid;
    logic [8:0]  tx_data;
    logic        tx_ready = 1'b0, tx_busy = 1'b0;
    logic [15:0] frame_cfg;
    logic [14:0] clk_div;
    logic        rx_pin_en, tx_pin_en;
    logic [2:0]  pin_loc;
    logic        irq;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    serial_ctl_regs i_serial_ctl_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .tx_busy(tx_busy), .frame_cfg(frame_cfg), .clk_div(clk_div),
        .rx_pin_en(rx_pin_en), .tx_pin_en(tx_pin_en), .pin_loc(pin_loc), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic rx_put(input logic [8:0] d, input logic pe, input logic fe);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d; rx_perr = pe; rx_ferr = fe;
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic tx_take();
        @(negedge clk);
        tx_ready = 1'b1; tx_busy = 1'b1;
        @(posedge clk); #1;
        tx_ready = 1'b0;
    endtask

    function automatic logic [31:0] rx_word(input logic [8:0] d, input logic pe, input logic fe);
        return {16'h0, fe, pe, 5'h0, d};
    endfunction

    function automatic logic model_irq(input logic [7:0] f, input logic [7:0] en);
        return |((f | 8'h02) & en);
    endfunction

    initial begin
        #(4 * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] q[$];
        logic [7:0]  mf, men;
        void'($urandom(32'd4711));

        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state
        rd('h10, v); chk("R3 status reset", v, 32'h40);
        rd('h40, v); chk("R7 flags reset", v, 32'h02);
        chk("R8 irq reset", {31'b0, irq}, 0);
        chk("R2 rx_ready reset", {31'b0, rx_ready}, 0);

        // R1 configuration registers
        wr('h04, 32'hFFFF_FFFF); rd('h04, v);
        chk("R1 frame readback", v, 32'h330F);
        chk("R1 frame_cfg", {16'b0, frame_cfg}, 32'h330F);
        wr('h14, 32'h1234_5678); rd('h14, v);
        chk("R1 divider readback", v, 32'h1234_5678 & 32'h001F_FFC0);
        chk("R1 clk_div", {17'b0, clk_div}, (32'h1234_5678 & 32'h001F_FFC0) >> 6);
        wr('h08, 32'hFFFF_FFFF); rd('h08, v); chk("R1 unmapped read", v, 0);
        wr('h4C, 32'hFFFF_FFFF); rd('h4C, v); chk("R1 enable mask", v, 32'h17);
        wr('h4C, 0);

        // R12 route
        wr('h54, 32'hFFFF); rd('h54, v); chk("R12 route readback", v, 32'h703);
        chk("R12 pins all", {27'b0, pin_loc, tx_pin_en, rx_pin_en}, {27'b0, 3'd7, 2'b11});
        wr('h54, 32'h0502);
        chk("R12 pins loc5", {27'b0, pin_loc, tx_pin_en, rx_pin_en}, {27'b0, 3'd5, 2'b10});

        // R2 commands
        wr('h0C, 32'h1); chk("R2 rx enable", {31'b0, rx_ready}, 1);
        wr('h0C, 32'h3); chk("R2 disable wins", {31'b0, rx_ready}, 0);
        rd('h0C, v); chk("R2 command reads zero", v, 0);

        // transmit path
        wr('h00, 0);
        wr('h0C, 32'h4);
        rd('h10, v); chk("R3 status tx idle", v, 32'h62);
        wr('h34, 32'h11); wr('h34, 32'h22); wr('h34, 32'h33);
        chk("R9 tx_valid", {31'b0, tx_valid}, 1);
        chk("R9 first byte", {23'b0, tx_data}, 32'h11);
        rd('h10, v); chk("R4 full buffer level low", v, 32'h02);
        tx_take();
        wr('h00, 32'h1000);
        rd('h10, v); chk("R4 strict threshold one entry", v, 32'h02);
        rd('h00, v); chk("R1 control readback", v, 32'h1000);
        wr('h00, 0);
        rd('h10, v); chk("R4 loose threshold one entry", v, 32'h42);
        chk("R9 second byte", {23'b0, tx_data}, 32'h22);
        tx_take();
        chk("R9 third byte dropped", {31'b0, tx_valid}, 0);
        rd('h40, v); chk("R10 no completion while busy", v, 32'h02);
        @(negedge clk); tx_busy = 1'b0;
        repeat (3) @(posedge clk);
        rd('h40, v); chk("R10 completion flag", v, 32'h03);
        rd('h10, v); chk("R10 status idle", v, 32'h62);
        wr('h4C, 32'h1); chk("R8 irq on completion", {31'b0, irq}, 1);
        wr('h48, 32'h1); chk("R7 clear alias irq", {31'b0, irq}, 0);
        rd('h40, v); chk("R7 cleared flags", v, 32'h02);
        wr('h44, 32'h02); rd('h40, v); chk("R7 level bit ignores set", v, 32'h02);
        wr('h4C, 32'h2); chk("R8 level irq", {31'b0, irq}, 1);
        wr('h4C, 0);

        // R11 transmit flush
        wr('h34, 32'h44); wr('h34, 32'h55);
        wr('h0C, 32'h8); chk("R11 flush tx_valid", {31'b0, tx_valid}, 0);
        wr('h0C, 32'h4); chk("R11 flushed after re-enable", {31'b0, tx_valid}, 0);
        rd('h10, v); chk("R11 status empty", v, 32'h62);
        wr('h0C, 32'h8);
        wr('h34, 32'h66); wr('h0C, 32'h4);
        chk("R9 write while disabled dropped", {31'b0, tx_valid}, 0);
        wr('h0C, 32'h8);

        // receive path
        wr('h0C, 32'h1);
        rx_put(9'h1A5, 1'b1, 1'b0);
        rx_put(9'h003, 1'b0, 1'b1);
        rx_put(9'h0FF, 1'b0, 1'b0);
        rd('h40, v); chk("R6 overflow flag", v, 32'h16);
        rd('h10, v); chk("R3 status rx data", v, 32'hC0);
        rd('h18, v); chk("R5 first entry", v, rx_word(9'h1A5, 1'b1, 1'b0));
        rd('h18, v); chk("R5 second entry", v, rx_word(9'h003, 1'b0, 1'b1));
        rd('h18, v); chk("R6 dropped entry / R5 empty read", v, 0);
        rd('h10, v); chk("R5 empty status", v, 32'h40);

        // R7 clear beats overflow in same cycle
        wr('h48, 32'h14);
        rx_put(9'h010, 1'b0, 1'b0);
        rx_put(9'h020, 1'b0, 1'b0);
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h48; wdata = 32'h10;
        rx_valid = 1'b1; rx_data = 9'h030; rx_perr = 1'b0; rx_ferr = 1'b0;
        @(posedge clk); #1;
        wr_en = 1'b0; rx_valid = 1'b0;
        rd('h40, v); chk("R7 clear beats set", v, 32'h06);
        rd('h18, v); chk("R6 keep oldest", v, 32'h010);
        rd('h18, v); chk("R6 keep second", v, 32'h020);
        rd('h18, v); chk("R6 third dropped", v, 0);

        // R11 receiver disable keeps contents
        rx_put(9'h077, 1'b0, 1'b0);
        wr('h0C, 32'h2);
        chk("R11 rx refuses", {31'b0, rx_ready}, 0);
        rx_put(9'h099, 1'b0, 1'b0);
        rd('h18, v); chk("R11 entry kept", v, 32'h077);
        rd('h18, v); chk("R11 nothing taken while off", v, 0);

        // random mix against a model
        wr('h0C, 32'h1);
        wr('h48, 32'hFF);
        wr('h4C, 0);
        mf = 0; men = 0;
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom % 5);
            case (op)
                0: begin
                    logic [8:0] d; logic pe, fe;
                    d = 9'($urandom); pe = 1'($urandom); fe = 1'($urandom);
                    rx_put(d, pe, fe);
                    if (q.size() == 2) mf[4] = 1'b1;
                    else begin q.push_back(rx_word(d, pe, fe)); mf[2] = 1'b1; end
                end
                1: begin
                    logic [31:0] e;
                    e = (q.size() != 0) ? q.pop_front() : 32'h0;
                    rd('h18, v); chk("R5 random read", v, e);
                end
                2: begin
                    logic [31:0] w; w = $urandom;
                    wr('h44, w); mf = mf | (w[7:0] & 8'h15);
                end
                3: begin
                    logic [31:0] w; w = $urandom;
                    wr('h48, w); mf = mf & ~(w[7:0] & 8'h15);
                end
                default: begin
                    logic [31:0] w; w = $urandom;
                    wr('h4C, w); men = w[7:0] & 8'h17;
                end
            endcase
            chk("R8 random irq", {31'b0, irq}, {31'b0, model_irq(mf, men)});
            if (i % 16 == 0) begin
                rd('h40, v); chk("R7 random flags", v, {24'b0, mf | 8'h02});
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule